// File: doc/BRIEF.md
# Single-Fetch TLB Refill Engine

This block services misses from both the instruction TLB and the data TLB. It does this with one memory read from a page-table array that sits in virtual address space. When a miss is accepted, the engine works out where the matching table entry lives. That location is a base register plus the page number of the missing address, scaled to a four-byte entry. The table is linear: 4 MB of virtual space holding 1024 pages of entries.

The engine then asks the data TLB to translate that table location. It does this even when the original miss came from the instruction side. If the data TLB holds no mapping for the location, the engine gives up at once and reports a table-miss fault, so that an exception handler can install the mapping. If a mapping is found, the engine issues exactly one read at privilege ring 0. The read carries the cacheability of the data TLB entry that translated it. The returned word is handed to the TLB that missed, and the faulting access is told to restart. A read that comes back with a bus error ends the attempt with its own fault code.

Top module: `pte_refill_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `lk_req`, `rd_valid`, `fill_valid` and `fault_valid` are all 0.
- R2: The table-entry address presented on `lk_vaddr` equals `tbl_base + (miss_vaddr >> 12) * 4`, modulo 2^32.
- R3: When both miss inputs are valid in the same idle cycle, the data side wins: `dmiss_ack` is 1 and `imiss_ack` is 0. The other miss waits until a later idle cycle.
- R4: Every accepted miss causes exactly one data-TLB lookup (`lk_req` high for one cycle), whichever side missed.
- R5: If the lookup reports no hit, no read is issued. One cycle later `fault_valid` pulses with `fault_code` = 1.
- R6: On a lookup hit, exactly one read is made. `rd_addr` equals the translated address and `rd_ring` is 0. `rd_cacheable` equals the lookup's cacheability bit. `rd_valid` and `rd_addr` are held until `rd_ready`.
- R7: A response without error makes `fill_valid` pulse for one cycle on the following edge. It carries `fill_pte` equal to the response word, with `out_instr` (1 = instruction TLB) and `out_vaddr` naming the miss.
- R8: A response with `rsp_err` set makes `fault_valid` pulse with `fault_code` = 2, and no fill occurs.
- R9: While `busy` is 1, new misses are not accepted: both acknowledges stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | 32 | Virtual base of the linear page table |
| imiss_valid | input | 1 | Instruction TLB miss pending |
| imiss_vaddr | input | 32 | Instruction miss address |
| imiss_ack | output | 1 | Instruction miss accepted this cycle |
| dmiss_valid | input | 1 | Data TLB miss pending |
| dmiss_vaddr | input | 32 | Data miss address |
| dmiss_ack | output | 1 | Data miss accepted this cycle |
| busy | output | 1 | Refill in progress |
| lk_req | output | 1 | Data TLB lookup request |
| lk_vaddr | output | 32 | Table-entry virtual address to translate |
| lk_hit | input | 1 | Lookup found a mapping |
| lk_paddr | input | 32 | Translated physical address |
| lk_cacheable | input | 1 | Cacheability of the translating entry |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | 32 | Physical read address |
| rd_ring | output | 2 | Privilege ring of the read |
| rd_cacheable | output | 1 | Read cacheability |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 32 | Returned word |
| rsp_err | input | 1 | Bus error on the read |
| fill_valid | output | 1 | Write `fill_pte` into the missing TLB and restart |
| fill_pte | output | 32 | Entry to install |
| fault_valid | output | 1 | Refill aborted |
| fault_code | output | 2 | 1 = table miss, 2 = bus error |
| out_instr | output | 1 | Side of the current miss (1 = instruction) |
| out_vaddr | output | 32 | Address of the current miss |

## Verification
Some behaviours are checked by assertions on every cycle:
- the lookup pulse lasts a single cycle;
- a read request holds while it is not taken and drops once it is accepted;
- a lookup miss leads straight to a table-miss fault;
- a bus error leads to a bus-error fault;
- a fill follows only an error-free response;
- the data side has priority;
- no miss is acknowledged while busy.

Other behaviours can only be shown by the bench's sweeps over sides, addresses, bases, outcomes and memory delays:
- the arithmetic of the table-entry address;
- the pass-through of the translated address and cacheability;
- the installed word;
- the miss that was held back being served later.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLATE,
    ST_READ,
    ST_FILL,
    ST_FAULT
  } refill_state_t;

  localparam logic [1:0] FC_NONE     = 2'd0;
  localparam logic [1:0] FC_TBL_MISS = 2'd1;
  localparam logic [1:0] FC_BUS_ERR  = 2'd2;
endpackage

// File: rtl/refill_arb.sv
module refill_arb #(
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            i_valid,
  input  logic [VA_W-1:0] i_va,
  input  logic            d_valid,
  input  logic [VA_W-1:0] d_va,
  output logic            i_ack,
  output logic            d_ack,
  output logic            take,
  output logic            sel_instr,
  output logic [VA_W-1:0] sel_va
);
  always_comb begin
    d_ack     = en && d_valid;
    i_ack     = en && i_valid && !d_valid;
    take      = d_ack || i_ack;
    sel_instr = !d_valid;
    sel_va    = d_valid ? d_va : i_va;
  end

  assert_data_first_R3: assert property (@(posedge clk) disable iff (rst)
    (en && d_valid && i_valid) |-> (d_ack && !i_ack));
  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({i_ack, d_ack}));
endmodule

// File: rtl/refill_addr.sv
module refill_addr #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_LOG    = 2
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] pte_va
);
  logic [VA_W-1:0] vpn;
  always_comb begin
    vpn    = va >> PAGE_SHIFT;
    pte_va = base + (vpn << PTE_LOG);
  end
endmodule

// File: rtl/pte_refill_engine.sv
module pte_refill_engine
  import refill_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int RING_W     = 2,
  parameter int PAGE_SHIFT = 12,
  parameter int PTE_LOG    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VA_W-1:0]   tbl_base,
  input  logic              imiss_valid,
  input  logic [VA_W-1:0]   imiss_vaddr,
  output logic              imiss_ack,
  input  logic              dmiss_valid,
  input  logic [VA_W-1:0]   dmiss_vaddr,
  output logic              dmiss_ack,
  output logic              busy,
  output logic              lk_req,
  output logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_hit,
  input  logic [PA_W-1:0]   lk_paddr,
  input  logic              lk_cacheable,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [PA_W-1:0]   rd_addr,
  output logic [RING_W-1:0] rd_ring,
  output logic              rd_cacheable,
  input  logic              rsp_valid,
  input  logic [PTE_W-1:0]  rsp_data,
  input  logic              rsp_err,
  output logic              fill_valid,
  output logic [PTE_W-1:0]  fill_pte,
  output logic              fault_valid,
  output logic [1:0]        fault_code,
  output logic              out_instr,
  output logic [VA_W-1:0]   out_vaddr
);
  localparam logic [RING_W-1:0] KERNEL_RING = '0;

  refill_state_t   state_q;
  logic            instr_q;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] pa_q;
  logic            cach_q;
  logic            issued_q;
  logic [PTE_W-1:0] pte_q;
  logic [1:0]      code_q;

  logic            take;
  logic            sel_instr;
  logic [VA_W-1:0] sel_va;
  logic [VA_W-1:0] pte_va;

  refill_arb #(.VA_W(VA_W)) u_arb (
    .clk(clk), .rst(rst), .en(state_q == ST_IDLE),
    .i_valid(imiss_valid), .i_va(imiss_vaddr),
    .d_valid(dmiss_valid), .d_va(dmiss_vaddr),
    .i_ack(imiss_ack), .d_ack(dmiss_ack),
    .take(take), .sel_instr(sel_instr), .sel_va(sel_va)
  );

  refill_addr #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PTE_LOG(PTE_LOG)) u_addr (
    .base(tbl_base), .va(va_q), .pte_va(pte_va)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      instr_q  <= 1'b0;
      va_q     <= '0;
      pa_q     <= '0;
      cach_q   <= 1'b0;
      issued_q <= 1'b0;
      pte_q    <= '0;
      code_q   <= FC_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          instr_q  <= sel_instr;
          va_q     <= sel_va;
          issued_q <= 1'b0;
          state_q  <= ST_XLATE;
        end
        ST_XLATE: if (lk_hit) begin
          pa_q    <= lk_paddr;
          cach_q  <= lk_cacheable;
          state_q <= ST_READ;
        end else begin
          code_q  <= FC_TBL_MISS;
          state_q <= ST_FAULT;
        end
        ST_READ: begin
          if (!issued_q && rd_ready) issued_q <= 1'b1;
          if (issued_q && rsp_valid) begin
            if (rsp_err) begin
              code_q  <= FC_BUS_ERR;
              state_q <= ST_FAULT;
            end else begin
              pte_q   <= rsp_data;
              state_q <= ST_FILL;
            end
          end
        end
        ST_FILL:  state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = state_q != ST_IDLE;
    lk_req       = state_q == ST_XLATE;
    lk_vaddr     = pte_va;
    rd_valid     = (state_q == ST_READ) && !issued_q;
    rd_addr      = pa_q;
    rd_ring      = KERNEL_RING;
    rd_cacheable = cach_q;
    fill_valid   = state_q == ST_FILL;
    fill_pte     = pte_q;
    fault_valid  = state_q == ST_FAULT;
    fault_code   = code_q;
    out_instr    = instr_q;
    out_vaddr    = va_q;
  end

  assert_lookup_single_R4: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> !lk_req);
  assert_tbl_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !lk_hit) |=> (fault_valid && fault_code == FC_TBL_MISS && !rd_valid));
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_one_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> !rd_valid);
  assert_fill_source_R7: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $past(rsp_valid && !rsp_err));
  assert_bus_fault_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && issued_q && rsp_valid && rsp_err) |=>
      (fault_valid && fault_code == FC_BUS_ERR && !fill_valid));
  assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!imiss_ack && !dmiss_ack));
endmodule

// File: tb/pte_refill_engine_bench.sv
module pte_refill_engine_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] tbl_base = '0;
  logic imiss_valid = 0, dmiss_valid = 0;
  logic [31:0] imiss_vaddr = '0, dmiss_vaddr = '0;
  logic imiss_ack, dmiss_ack, busy, lk_req, lk_hit, lk_cacheable;
  logic [31:0] lk_vaddr, lk_paddr, rd_addr, fill_pte, out_vaddr;
  logic rd_valid, rd_ready = 0, rd_cacheable, rsp_valid = 0, rsp_err = 0;
  logic [1:0] rd_ring, fault_code;
  logic [31:0] rsp_data = '0;
  logic fill_valid, fault_valid, out_instr;
  logic tlb_hit_mode = 1'b1;

  localparam logic [31:0] PA_XOR  = 32'h8000_0000;
  localparam logic [31:0] PTE_XOR = 32'h5A5A_A5A5;

  always_comb begin
    lk_hit       = tlb_hit_mode;
    lk_paddr     = lk_vaddr ^ PA_XOR;
    lk_cacheable = lk_vaddr[13];
  end

  pte_refill_engine u_pte_refill_engine (
    .clk(clk), .rst(rst), .tbl_base(tbl_base),
    .imiss_valid(imiss_valid), .imiss_vaddr(imiss_vaddr), .imiss_ack(imiss_ack),
    .dmiss_valid(dmiss_valid), .dmiss_vaddr(dmiss_vaddr), .dmiss_ack(dmiss_ack),
    .busy(busy), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_cacheable(lk_cacheable),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_ring(rd_ring),
    .rd_cacheable(rd_cacheable), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .fill_valid(fill_valid), .fill_pte(fill_pte),
    .fault_valid(fault_valid), .fault_code(fault_code),
    .out_instr(out_instr), .out_vaddr(out_vaddr)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs from the negedge after acceptance until the outcome is seen.
  task automatic serve(input bit hit, input bit err, input int dly, input bit exp_i,
                       input logic [31:0] exp_va);
    logic [31:0] e_pte_va, e_pa, got_addr;
    int lk, rd, wait_c, ack_busy;
    bit rsp_next, done, seen_rd, got_fill, got_fault;
    logic [1:0] code;
    logic [31:0] pte, ova;
    logic oi;
    e_pte_va = tbl_base + ((exp_va >> 12) << 2);
    e_pa = e_pte_va ^ PA_XOR;
    lk = 0; rd = 0; wait_c = 0; ack_busy = 0;
    rsp_next = 0; done = 0; seen_rd = 0; got_fill = 0; got_fault = 0;
    code = '0; pte = '0; ova = '0; oi = 0; got_addr = '0;
    for (int cyc = 0; cyc < 40 && !done; cyc++) begin
      rd_ready  = 1'b0;
      rsp_valid = rsp_next;
      rsp_err   = err;
      rsp_data  = got_addr ^ PTE_XOR;
      rsp_next  = 0;
      #1;
      if (busy && (imiss_ack || dmiss_ack)) ack_busy++;
      if (lk_req) begin
        lk++;
        chk(lk_vaddr == e_pte_va, "R2 table-entry address", lk_vaddr, e_pte_va);
      end
      if (rd_valid) begin
        if (!seen_rd) begin
          seen_rd = 1;
          chk(rd_addr == e_pa, "R6 read address", rd_addr, e_pa);
          chk(rd_ring == 2'd0, "R6 ring 0", {30'd0, rd_ring}, 32'd0);
          chk(rd_cacheable == e_pte_va[13], "R6 cacheability", {31'd0, rd_cacheable},
              {31'd0, e_pte_va[13]});
        end
        if (wait_c == dly) begin
          rd_ready = 1'b1; rd++; rsp_next = 1; got_addr = rd_addr;
        end else wait_c++;
      end
      if (fill_valid || fault_valid) begin
        done = 1; got_fill = fill_valid; got_fault = fault_valid;
        code = fault_code; pte = fill_pte; ova = out_vaddr; oi = out_instr;
      end
      if (!done) @(negedge clk);
    end
    rd_ready = 0; rsp_valid = 0; rsp_err = 0;
    chk(done, "watchdog refill outcome", {31'd0, done}, 32'd1);
    chk(lk == 1, "R4 one lookup", lk, 1);
    chk(ack_busy == 0, "R9 no ack while busy", ack_busy, 0);
    chk(oi == exp_i && ova == exp_va, "R7 side and address", ova, exp_va);
    if (!hit) begin
      chk(rd == 0, "R5 no read on table miss", rd, 0);
      chk(got_fault && !got_fill && code == 2'd1, "R5 table-miss fault", {30'd0, code}, 32'd1);
    end else if (err) begin
      chk(rd == 1, "R6 one read", rd, 1);
      chk(got_fault && !got_fill && code == 2'd2, "R8 bus-error fault", {30'd0, code}, 32'd2);
    end else begin
      chk(rd == 1, "R6 one read", rd, 1);
      chk(got_fill && !got_fault, "R7 fill pulse", {31'd0, got_fill}, 32'd1);
      chk(pte == (e_pa ^ PTE_XOR), "R7 installed word", pte, e_pa ^ PTE_XOR);
    end
  endtask

  task automatic run_one(input bit instr, input logic [31:0] va, input bit hit,
                         input bit err, input int dly);
    @(negedge clk);
    tlb_hit_mode = hit;
    if (instr) begin imiss_valid = 1; imiss_vaddr = va; end
    else begin dmiss_valid = 1; dmiss_vaddr = va; end
    #1;
    chk(instr ? (imiss_ack && !dmiss_ack) : (dmiss_ack && !imiss_ack), "R3 acknowledge",
        {30'd0, imiss_ack, dmiss_ack}, instr ? 32'd2 : 32'd1);
    @(posedge clk);
    @(negedge clk);
    imiss_valid = 0; dmiss_valid = 0;
    serve(hit, err, dly, instr, va);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] vas [6];
    logic [31:0] bases [2];
    int n;
    vas[0] = 32'h0000_0000; vas[1] = 32'hFFFF_FFFF; vas[2] = 32'h0000_0FFF;
    vas[3] = 32'h0000_1000; vas[4] = 32'h1234_5678; vas[5] = 32'h8000_2ABC;
    bases[0] = 32'hC000_0000; bases[1] = 32'h0040_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk(!busy && !lk_req && !rd_valid && !fill_valid && !fault_valid, "R1 reset state",
        {27'd0, busy, lk_req, rd_valid, fill_valid, fault_valid}, 32'd0);

    n = 0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int v = 0; v < 6; v++)
          for (int m = 0; m < 3; m++) begin
            tbl_base = bases[b];
            run_one(s[0], vas[v], m != 1, m == 2, n % 3);
            n++;
          end

    // R3: simultaneous misses, data first, instruction held until later
    tbl_base = 32'hC000_0000;
    @(negedge clk);
    tlb_hit_mode = 1;
    imiss_valid = 1; imiss_vaddr = 32'h0040_5000;
    dmiss_valid = 1; dmiss_vaddr = 32'h7777_3000;
    #1;
    chk(dmiss_ack && !imiss_ack, "R3 data side first", {30'd0, imiss_ack, dmiss_ack}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    dmiss_valid = 0;
    serve(1, 0, 1, 1'b0, 32'h7777_3000);
    @(negedge clk);
    #1;
    chk(imiss_ack && !dmiss_ack, "R3 held instruction miss served",
        {30'd0, imiss_ack, dmiss_ack}, 32'd2);
    @(posedge clk);
    @(negedge clk);
    imiss_valid = 0;
    serve(1, 0, 0, 1'b1, 32'h0040_5000);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule